// File: doc/BRIEF.md
# Reset Cause Vector Register

This block records why the device was last reset. Five event inputs (brownout, the external reset pin, a debugger-requested reset, the watchdog and protected-register access violations) each set a sticky pending flag. Several causes may be pending together. Software sees them through a single read-only vector register on a small memory-mapped bus with separate read and write strobes.

A read returns an even code that names the most urgent pending cause. The same read clears that cause's flag and nothing else. Software can therefore keep reading until it gets zero, and it collects every cause in priority order. A write, whatever its data, drops every remaining flag. Every read access has this side effect, including reads made by a debugger or monitor. There is no non-destructive peek.

Top module: `rst_cause_vec`

## Requirements
- R1: After the synchronous reset `rst`, no flag is pending, `rd_valid` is low, and the first read returns 0.
- R2: A one-cycle pulse on `evt_i[k]` sets flag k. The flag stays set until a read reports it or a write clears it.
- R3: A read returns code 2*(k+1) for the pending flag k with the lowest index. The indices are: brownout 0 (code 2), reset pin 1 (code 4), debugger reset 2 (code 6), watchdog 3 (code 8), access violation 4 (code 10). Codes are zero-extended to `DATA_W` bits.
- R4: A read clears only the flag it reports. Lower-priority flags stay pending.
- R5: A read with no flag pending returns 0.
- R6: A write strobe clears all flags, whatever the value of `wr_data`.
- R7: Several events of the same cause before a read give exactly one report for that cause.
- R8: Causes are reported in priority order, whatever order they arrived in.
- R9: A brownout event clears the flags of the other causes and sets the brownout flag. Only other events in that same cycle survive.
- R10: An event that arrives in the same cycle as a read or write that would clear its flag leaves that flag set.
- R11: `rd_data` and `rd_valid` are registered. They show the result in the cycle after `rd_req`. The clear happens on that same edge, so reads on consecutive cycles return successive causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_CAUSES | One-cycle reset-cause event pulses, index = priority |
| rd_req | input | 1 | Read strobe for the vector register |
| wr_req | input | 1 | Write strobe, clears all flags |
| wr_data | input | DATA_W | Write data, ignored |
| rd_data | output | DATA_W | Registered vector code |
| rd_valid | output | 1 | High one cycle after a read strobe |

## Verification
The two functions that can meet in one cycle are event capture and flag clearing, whether the clear comes from a read pop, a write or a brownout. The bench provokes each collision on purpose. It pulses watchdog during a read that pops watchdog, pulses the pin during a write, and pulses other causes together with brownout. A reference flag model in the bench lets the new event win, and it judges the outcome by the codes that later reads return.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  parameter int NUM_CAUSES_DEF = 5;
  parameter int DATA_W_DEF     = 16;

  typedef enum int {
    CAUSE_BROWNOUT  = 0,
    CAUSE_PIN       = 1,
    CAUSE_DEBUG     = 2,
    CAUSE_WATCHDOG  = 3,
    CAUSE_VIOLATION = 4
  } cause_e;

  function automatic int code_width(input int n);
    return $clog2(2 * n + 1);
  endfunction
endpackage

// File: rtl/rcv_prio_enc.sv
module rcv_prio_enc #(
  parameter int N      = rcv_pkg::NUM_CAUSES_DEF,
  parameter int CODE_W = rcv_pkg::code_width(N)
) (
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      top_oh,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    top_oh = '0;
    code   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        top_oh    = '0;
        top_oh[i] = 1'b1;
        code      = CODE_W'(2 * (i + 1));
      end
    end
  end
endmodule

// File: rtl/rcv_flag_bank.sv
module rcv_flag_bank #(
  parameter int N = rcv_pkg::NUM_CAUSES_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] pop_oh,
  input  logic         clr_all,
  output logic [N-1:0] pend_q
);
  localparam int BOR = rcv_pkg::CAUSE_BROWNOUT;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      logic clr;
      if (g == BOR) begin : g_bor
        assign clr = pop_oh[g] | clr_all;
      end else begin : g_other
        assign clr = pop_oh[g] | clr_all | evt[BOR];
      end
      always_ff @(posedge clk) begin
        if (rst) pend_q[g] <= 1'b0;
        else     pend_q[g] <= evt[g] | (pend_q[g] & ~clr);
      end
    end
  endgenerate
endmodule

// File: rtl/rcv_bus_if.sv
module rcv_bus_if #(
  parameter int N      = rcv_pkg::NUM_CAUSES_DEF,
  parameter int DATA_W = rcv_pkg::DATA_W_DEF,
  parameter int CODE_W = rcv_pkg::code_width(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [N-1:0]      top_oh,
  input  logic [CODE_W-1:0] code,
  output logic [N-1:0]      pop_oh,
  output logic              clr_all,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  assign pop_oh  = rd_req ? top_oh : '0;
  assign clr_all = wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= DATA_W'(code);
    end
  end
endmodule

// File: rtl/rst_cause_vec.sv
module rst_cause_vec #(
  parameter int NUM_CAUSES = rcv_pkg::NUM_CAUSES_DEF,
  parameter int DATA_W     = rcv_pkg::DATA_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CAUSES-1:0] evt_i,
  input  logic                  rd_req,
  input  logic                  wr_req,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid
);
  localparam int CODE_W = rcv_pkg::code_width(NUM_CAUSES);

  logic [NUM_CAUSES-1:0] pend_q;
  logic [NUM_CAUSES-1:0] top_oh;
  logic [NUM_CAUSES-1:0] pop_oh;
  logic [CODE_W-1:0]     code;
  logic                  clr_all;
  logic                  unused_wdata;

  assign unused_wdata = ^wr_data;

  rcv_flag_bank #(.N(NUM_CAUSES)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_i), .pop_oh(pop_oh),
    .clr_all(clr_all), .pend_q(pend_q)
  );

  rcv_prio_enc #(.N(NUM_CAUSES), .CODE_W(CODE_W)) u_enc (
    .pend(pend_q), .top_oh(top_oh), .code(code)
  );

  rcv_bus_if #(.N(NUM_CAUSES), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_bus (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .top_oh(top_oh), .code(code), .pop_oh(pop_oh), .clr_all(clr_all),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker #(
  parameter int N      = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      evt_i,
  input logic              rd_req,
  input logic              wr_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [N-1:0]      flags
);
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst) rd_req |=> rd_valid); // R11
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !rd_req |=> !rd_valid); // R11
  AST_CODE_EVEN: assert property (@(posedge clk) disable iff (rst) rd_valid |-> (rd_data[0] == 1'b0 && rd_data <= DATA_W'(2 * N))); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst) (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i))); // R10
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst) (wr_req && evt_i == '0) |=> flags == '0); // R6
  AST_BOR_ONLY: assert property (@(posedge clk) disable iff (rst) (evt_i == N'(1) && !rd_req && !wr_req) |=> flags == N'(1)); // R9
  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst) (rd_req && !wr_req && evt_i == '0 && flags != '0) |=> $countones(flags) == $countones($past(flags)) - 1); // R4
endmodule

bind rst_cause_vec rcv_checker #(.N(NUM_CAUSES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .rd_req(rd_req), .wr_req(wr_req),
  .rd_data(rd_data), .rd_valid(rd_valid), .flags(pend_q)
);

// File: tb/tb_rst_cause_vec.sv
`timescale 1ns/1ps
module tb_rst_cause_vec;
  localparam int N = 5;
  localparam int DW = 16;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0] evt_i = '0;
  logic rd_req = 0, wr_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  int checks = 0, fails = 0, cyc = 0;
  logic [N-1:0] model = '0;
  logic rd_seen = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rst_cause_vec #(.NUM_CAUSES(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .rd_req(rd_req), .wr_req(wr_req),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic int top_idx(input logic [N-1:0] f);
    for (int i = 0; i < N; i++) if (f[i]) return i;
    return -1;
  endfunction

  // driver: called at a negedge, applies one cycle of stimulus
  task automatic step(input logic [N-1:0] e, input logic r, input logic w,
                      input logic [DW-1:0] d, input string tag);
    int t;
    logic [N-1:0] nm;
    t = top_idx(model);
    if (r) begin
      exp_q.push_back(t < 0 ? 0 : 2 * (t + 1));
      tag_q.push_back(tag);
    end
    for (int i = 0; i < N; i++) begin
      logic clr;
      clr = (r && i == t) || w || (e[0] && i != 0);
      nm[i] = e[i] | (model[i] & ~clr);
    end
    model = nm;
    evt_i = e; rd_req = r; wr_req = w; wr_data = d;
    @(negedge clk);
    evt_i = '0; rd_req = 0; wr_req = 0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= rd_req;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_valid !== rd_seen) begin
        fails++;
        $display("FAIL R11 rd_valid actual=%0b expected=%0b", rd_valid, rd_seen);
      end
      if (rd_valid) begin
        int e;
        string tg;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected read data actual=%0d expected=none", rd_data);
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          checks++;
          if (rd_data !== DW'(e)) begin
            fails++;
            $display("FAIL %s rd_data actual=%0d expected=%0d", tg, rd_data, e);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1 after reset actual=%0b/%0d expected=0/0", rd_valid, rd_data);
    end
    step('0, 1, 0, 0, "R1");                 // R1, R5: empty read gives 0
    idle(1);
    step(5'b01000, 0, 0, 0, "R2");           // watchdog
    idle(2);
    step('0, 1, 0, 0, "R2 R3");              // 8
    step('0, 1, 0, 0, "R5");                 // 0
    // R7 R8: violation pulsed three times, then pin
    step(5'b10000, 0, 0, 0, "R7");
    step(5'b10000, 0, 0, 0, "R7");
    idle(1);
    step(5'b10000, 0, 0, 0, "R7");
    step(5'b00010, 0, 0, 0, "R8");
    step('0, 1, 0, 0, "R8");                 // 4
    step('0, 1, 0, 0, "R7");                 // 10 once
    step('0, 1, 0, 0, "R7");                 // 0
    // R6: write clears everything regardless of data
    step(5'b11110, 0, 0, 0, "R6");
    step('0, 0, 1, 16'hBEEF, "R6");
    step('0, 1, 0, 0, "R6");                 // 0
    // R9: brownout drops older causes
    step(5'b10100, 0, 0, 0, "R9");
    step(5'b00001, 0, 0, 0, "R9");
    step('0, 1, 0, 0, "R9");                 // 2
    step('0, 1, 0, 0, "R9");                 // 0
    step(5'b00100, 0, 0, 0, "R9");
    step(5'b01001, 0, 0, 0, "R9");           // brownout with same-cycle watchdog
    step('0, 1, 0, 0, "R9");                 // 2
    step('0, 1, 0, 0, "R9");                 // 8
    step('0, 1, 0, 0, "R9");                 // 0
    // R10: event wins over read pop and over write
    step(5'b01000, 0, 0, 0, "R10");
    step(5'b01000, 1, 0, 0, "R10");          // 8, flag stays
    step('0, 1, 0, 0, "R10");                // 8 again
    step('0, 1, 0, 0, "R10");                // 0
    step(5'b00100, 0, 0, 0, "R10");
    step(5'b00010, 0, 1, 16'h0001, "R10");   // write clears debug, pin survives
    step('0, 1, 0, 0, "R10");                // 4
    step('0, 1, 0, 0, "R10");                // 0
    // R4 R11: back-to-back reads drain in order
    step(5'b01110, 0, 0, 0, "R4");
    step('0, 1, 0, 0, "R4 R11");             // 4
    step('0, 1, 0, 0, "R4 R11");             // 6
    step('0, 1, 0, 0, "R4 R11");             // 8
    step('0, 1, 0, 0, "R4 R11");             // 0
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 reads outstanding actual=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule